// File: doc/BRIEF.md
# Descriptor-Driven DMA Command Sequencer

This block is the control engine of one descriptor-based DMA channel. Once started, it reads a chain of 16-byte command descriptors from memory. Each descriptor tells it to do one of four things: move bytes between memory and a byte stream, move one 32-bit word to or from a device register, do nothing, or halt. After the work is done, the block checks a wait condition, writes the residual count and a status snapshot back into the descriptor, and may raise an interrupt. It then moves on to the next descriptor, or jumps to another one when the branch condition is met.

Three conditions are tested for every descriptor: interrupt, branch and wait. Each has a 16-bit select input. The upper byte of the select is a mask and the lower byte is a compare value, and both are applied to the 8-bit device status. Every descriptor carries a 2-bit mode for each condition, so one chain can loop, wait for a device or signal software without any outside help.

The memory port is a simple request/acknowledge port on aligned 32-bit words. A request and its acknowledge complete in the same cycle, and read data comes back with the acknowledge. The outgoing and incoming byte streams use valid/ready. On the outgoing stream, data is held stable while ready is low. On the incoming stream, the block raises ready only while it has space for one byte, so a source that is kept waiting simply holds its byte. The device-register port holds its request until it is acknowledged.

Top module: `dsq_seq`

## Requirements
- R1: Rising `run` loads the descriptor pointer from `cmd_start` with bits 3:0 cleared. Each descriptor is read as three little-endian words: word 0 holds the request count in bits 15:0 and the command word in bits 31:16, word 1 holds the data address, and word 2 holds the dependent word. Command word bits 14:12 are the opcode: 0 send, 1 send-final, 2 receive, 3 receive-final, 4 device write, 5 device read, 6 no-op, 7 halt.
- R2: The send opcodes read request-count bytes starting at the data address, at any byte alignment, and present them in order on `tx_data`. `tx_last` is high only on the final byte of send-final. `tx_stream` shows command word bits 9:8. While `tx_ready` is low, `tx_valid` and `tx_data` hold.
- R3: The receive opcodes write each accepted byte to the next data address using a single byte enable. Receive stops after request-count bytes. Receive-final also stops after a byte that arrives with `rx_last` high. Plain receive ignores `rx_last`.
- R4: Device write puts the dependent word on `dev_wdata` at address `dev_addr`, equal to the data address. Device read stores `dev_rdata` into descriptor word 2.
- R5: A condition is true when (dev_status & sel[15:8]) == (sel[7:0] & sel[15:8]). A 2-bit mode of 0 gives never, 1 gives condition true, 2 gives condition false, and 3 gives always. Command word bits 5:4 hold the interrupt mode, bits 3:2 the branch mode and bits 1:0 the wait mode.
- R6: When the branch fires, the next descriptor address is the dependent word with bits 3:0 cleared, and the branch-taken status bit is set. Otherwise the pointer advances by 16 and the bit is cleared.
- R7: While the wait condition holds, the block stalls before write-back, with `status` bit 10 still high.
- R8: Write-back stores descriptor word 3 as {status, request count minus bytes moved}. The status word is: bit 15 run, bit 14 pause, bit 10 active, bit 8 branch taken, bits 7:0 device status, and all other bits 0.
- R9: `irq` is a single-cycle pulse after write-back when the interrupt condition fires.
- R10: The halt opcode drops the active bit, performs no write-back and issues no further memory requests until `run` is taken low and raised again.
- R11: When `run` is low, the current command is abandoned on the next edge. Active, `tx_valid`, `mem_req` and `dev_req` are then low.
- R12: While `pause` is high, no descriptor fetch is issued.
- R13: After reset, `status` bits 10 and 8 are 0, and `irq`, `mem_req`, `tx_valid`, `rx_ready` and `dev_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Channel enable; a rise starts the chain |
| pause | input | 1 | Hold at the next descriptor fetch |
| cmd_start | input | AW | First descriptor address |
| int_sel | input | 16 | Interrupt condition mask/value |
| br_sel | input | 16 | Branch condition mask/value |
| wait_sel | input | 16 | Wait condition mask/value |
| dev_status | input | 8 | Device status bits |
| status | output | 16 | Channel status word |
| irq | output | 1 | Interrupt pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write |
| mem_be | output | 4 | Byte enables |
| mem_addr | output | AW | Word-aligned address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with ack |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Sink ready |
| tx_data | output | 8 | Outgoing byte |
| tx_last | output | 1 | Final byte marker |
| tx_stream | output | 2 | Stream number |
| rx_valid | input | 1 | Incoming byte valid |
| rx_ready | output | 1 | Block can accept a byte |
| rx_data | input | 8 | Incoming byte |
| rx_last | input | 1 | End marker |
| dev_req | output | 1 | Device register request |
| dev_we | output | 1 | Device register write |
| dev_addr | output | AW | Device register address |
| dev_wdata | output | 32 | Device write data |
| dev_ack | input | 1 | Device request done |
| dev_rdata | input | 32 | Device read data |

## Verification
The start of a descriptor costs three fetch cycles. After that, each outgoing byte costs one memory read cycle and one stream cycle. Each incoming byte costs one stream cycle and one memory write cycle. The wait check, the write-back and the pointer update then take one cycle each, and `irq` follows the pointer update by one edge. The bench does not predict long chains cycle by cycle. It polls the active status bit on falling edges until the chain reaches its halt, and only then compares memory, the stream logs and the interrupt count. Results that depend on timing are checked on the falling edge one cycle after the stimulus: the abort on `run`, the pause hold and the wait stall, which is sampled at fixed delays while the condition is still held.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
  localparam int WORD_BYTES = 4;
  localparam int DESC_BYTES = 16;
  localparam int CNT_W      = 16;
  localparam int DATA_W     = 32;

  localparam int ST_RUN    = 15;
  localparam int ST_PAUSE  = 14;
  localparam int ST_ACTIVE = 10;
  localparam int ST_BT     = 8;

  typedef enum logic [2:0] {
    OP_SEND      = 3'd0,
    OP_SEND_FIN  = 3'd1,
    OP_RECV      = 3'd2,
    OP_RECV_FIN  = 3'd3,
    OP_DEV_WR    = 3'd4,
    OP_DEV_RD    = 3'd5,
    OP_NOP       = 3'd6,
    OP_HALT      = 3'd7
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_F0, S_F1, S_F2, S_EXEC, S_ORD, S_OTX, S_IRX, S_IWR,
    S_DEV, S_LDW, S_WAIT, S_WB, S_NEXT, S_HALT
  } st_e;

  // 0 never, 1 when true, 2 when false, 3 always
  function automatic logic mode_fire(input logic [1:0] mode, input logic c);
    case (mode)
      2'd0:    mode_fire = 1'b0;
      2'd1:    mode_fire = c;
      2'd2:    mode_fire = ~c;
      default: mode_fire = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/dsq_cond.sv
module dsq_cond #(
  parameter int N = 3
) (
  input  logic [N-1:0][15:0] sel,
  input  logic [7:0]         dstat,
  output logic [N-1:0]       hit
);
  for (genvar g = 0; g < N; g++) begin : g_cond
    assign hit[g] = ((dstat & sel[g][15:8]) == (sel[g][7:0] & sel[g][15:8]));
  end
endmodule

// File: rtl/dsq_lane.sv
module dsq_lane (
  input  logic [1:0]  lane,
  input  logic [31:0] rword,
  output logic [7:0]  rbyte,
  input  logic [7:0]  wbyte,
  output logic [31:0] wword,
  output logic [3:0]  wbe
);
  assign rbyte = rword[8*lane +: 8];
  assign wword = {4{wbyte}};
  assign wbe   = 4'b0001 << lane;
endmodule

// File: rtl/dsq_seq.sv
module dsq_seq
  import dsq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              pause,
  input  logic [AW-1:0]     cmd_start,
  input  logic [15:0]       int_sel,
  input  logic [15:0]       br_sel,
  input  logic [15:0]       wait_sel,
  input  logic [7:0]        dev_status,
  output logic [15:0]       status,
  output logic              irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [3:0]        mem_be,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic [1:0]        tx_stream,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  output logic              dev_req,
  output logic              dev_we,
  output logic [AW-1:0]     dev_addr,
  output logic [DATA_W-1:0] dev_wdata,
  input  logic              dev_ack,
  input  logic [DATA_W-1:0] dev_rdata
);
  localparam int DLOW = $clog2(DESC_BYTES);
  localparam int WLOW = $clog2(WORD_BYTES);

  st_e              st;
  logic [AW-1:0]    ptr, daddr;
  logic [CNT_W-1:0] req, cnt;
  logic [15:0]      cmdw;
  logic [DATA_W-1:0] dep;
  logic [7:0]       byte_q;
  logic             eob, bt, irq_q;

  op_e  op;
  assign op = op_e'(cmdw[14:12]);

  logic [2:0] hit;
  dsq_cond #(.N(3)) u_cond (
    .sel   ({wait_sel, br_sel, int_sel}),
    .dstat (dev_status),
    .hit   (hit)
  );
  logic int_go, br_go, wait_go;
  assign int_go  = mode_fire(cmdw[5:4], hit[0]);
  assign br_go   = mode_fire(cmdw[3:2], hit[1]);
  assign wait_go = mode_fire(cmdw[1:0], hit[2]);

  logic [AW-1:0] cur_addr;
  assign cur_addr = daddr + AW'(cnt);

  logic [7:0]  rd_byte;
  logic [31:0] wr_word;
  logic [3:0]  wr_be;
  dsq_lane u_lane (
    .lane  (cur_addr[1:0]),
    .rword (mem_rdata),
    .rbyte (rd_byte),
    .wbyte (byte_q),
    .wword (wr_word),
    .wbe   (wr_be)
  );

  logic final_byte;
  assign final_byte = ({1'b0, cnt} + 17'd1) == {1'b0, req};

  logic active;
  assign active = (st != S_IDLE) && (st != S_HALT);
  assign status = {run, pause, 3'b000, active, 1'b0, bt, dev_status};
  assign irq    = irq_q;

  logic [CNT_W-1:0] residual;
  assign residual = req - cnt;

  // memory port
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_be    = 4'hF;
    mem_addr  = ptr;
    mem_wdata = wr_word;
    case (st)
      S_F0:  mem_req = ~pause;
      S_F1:  begin mem_req = 1'b1; mem_addr = ptr + AW'(4); end
      S_F2:  begin mem_req = 1'b1; mem_addr = ptr + AW'(8); end
      S_ORD: begin mem_req = 1'b1; mem_addr = {cur_addr[AW-1:WLOW], {WLOW{1'b0}}}; end
      S_IWR: begin
        mem_req  = 1'b1; mem_we = 1'b1; mem_be = wr_be;
        mem_addr = {cur_addr[AW-1:WLOW], {WLOW{1'b0}}};
      end
      S_LDW: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = ptr + AW'(8); mem_wdata = dep; end
      S_WB:  begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = ptr + AW'(12);
        mem_wdata = {status, residual};
      end
      default: ;
    endcase
  end

  assign tx_valid  = (st == S_OTX);
  assign tx_data   = byte_q;
  assign tx_last   = (st == S_OTX) && (op == OP_SEND_FIN) && final_byte;
  assign tx_stream = cmdw[9:8];
  assign rx_ready  = (st == S_IRX);
  assign dev_req   = (st == S_DEV);
  assign dev_we    = (op == OP_DEV_WR);
  assign dev_addr  = daddr;
  assign dev_wdata = dep;

  logic unused_bits;
  assign unused_bits = ^{cmdw[15], cmdw[11:10], cmdw[7:6], dep[DLOW-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ptr <= '0; daddr <= '0; req <= '0; cnt <= '0;
      cmdw <= '0; dep <= '0; byte_q <= '0; eob <= 1'b0; bt <= 1'b0; irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (!run) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: begin
            ptr <= {cmd_start[AW-1:DLOW], {DLOW{1'b0}}};
            bt  <= 1'b0;
            st  <= S_F0;
          end
          S_F0: if (mem_req && mem_ack) begin
            req <= mem_rdata[15:0]; cmdw <= mem_rdata[31:16]; st <= S_F1;
          end
          S_F1: if (mem_ack) begin daddr <= mem_rdata[AW-1:0]; st <= S_F2; end
          S_F2: if (mem_ack) begin dep <= mem_rdata; cnt <= '0; st <= S_EXEC; end
          S_EXEC: begin
            case (op)
              OP_SEND, OP_SEND_FIN: st <= (req == '0) ? S_WAIT : S_ORD;
              OP_RECV, OP_RECV_FIN: st <= (req == '0) ? S_WAIT : S_IRX;
              OP_DEV_WR, OP_DEV_RD: st <= S_DEV;
              OP_NOP:               st <= S_WAIT;
              default:              st <= S_HALT;
            endcase
          end
          S_ORD: if (mem_ack) begin byte_q <= rd_byte; st <= S_OTX; end
          S_OTX: if (tx_ready) begin
            cnt <= cnt + 1'b1;
            st  <= final_byte ? S_WAIT : S_ORD;
          end
          S_IRX: if (rx_valid) begin byte_q <= rx_data; eob <= rx_last; st <= S_IWR; end
          S_IWR: if (mem_ack) begin
            cnt <= cnt + 1'b1;
            st  <= (final_byte || (op == OP_RECV_FIN && eob)) ? S_WAIT : S_IRX;
          end
          S_DEV: if (dev_ack) begin
            if (op == OP_DEV_RD) begin dep <= dev_rdata; st <= S_LDW; end
            else st <= S_WAIT;
          end
          S_LDW: if (mem_ack) st <= S_WAIT;
          S_WAIT: if (!wait_go) begin bt <= br_go; st <= S_WB; end
          S_WB: if (mem_ack) st <= S_NEXT;
          S_NEXT: begin
            irq_q <= int_go;
            ptr   <= bt ? {dep[AW-1:DLOW], {DLOW{1'b0}}} : ptr + AW'(DESC_BYTES);
            st    <= S_F0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dsq_seq_chk.sv
module dsq_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic [15:0]   status,
  input logic          irq,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          rx_ready,
  input logic          dev_req,
  input logic          dev_ack,
  input logic [AW-1:0] dev_addr
);
  // R2
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && run) |=> (tx_valid && $stable(tx_data)));
  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R11
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!status[10] && !tx_valid && !mem_req && !dev_req));
  // R1
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));
  // R4
  dev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req && !dev_ack && run) |=> (dev_req && $stable(dev_addr)));
  // R3
  one_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_ready && tx_valid));
endmodule

bind dsq_seq dsq_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/dsq_seq_bench.sv
module dsq_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic run = 0, pause = 0;
  logic [31:0] cmd_start = 0;
  logic [15:0] int_sel = 0, br_sel = 0, wait_sel = 0;
  logic [7:0]  dev_status = 8'h5A;
  logic [15:0] status;
  logic irq, mem_req, mem_we, mem_ack;
  logic [3:0]  mem_be;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic tx_valid, tx_ready, tx_last, rx_valid, rx_ready, rx_last;
  logic [7:0] tx_data, rx_data;
  logic [1:0] tx_stream;
  logic dev_req, dev_we, dev_ack;
  logic [31:0] dev_addr, dev_wdata, dev_rdata;

  dsq_seq u_dsq_seq (.*);

  int checks = 0, errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // memory model
  logic [31:0] mem [0:255];
  assign mem_ack   = mem_req;
  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk)
    if (mem_req && mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];

  // device model
  logic [31:0] dv_waddr = 0, dv_wdata = 0;
  assign dev_ack   = dev_req;
  assign dev_rdata = {16'h1234, dev_addr[15:0]};
  always @(posedge clk)
    if (dev_req && dev_we) begin dv_waddr <= dev_addr; dv_wdata <= dev_wdata; end

  // outgoing stream sink
  logic tx_hold = 0, tx_throttle = 0;
  assign tx_ready = !tx_hold && (!tx_throttle || cyc[0]);
  logic [7:0] tx_log [0:15];
  logic       tx_lastlog [0:15];
  logic [1:0] tx_idlog [0:15];
  int tx_n = 0;
  always @(posedge clk)
    if (tx_valid && tx_ready) begin
      tx_log[tx_n[3:0]] <= tx_data; tx_lastlog[tx_n[3:0]] <= tx_last;
      tx_idlog[tx_n[3:0]] <= tx_stream; tx_n <= tx_n + 1;
    end

  // incoming stream source
  logic [7:0] rx_src [0:15];
  logic       rx_lf  [0:15];
  int rx_len = 0, rx_idx = 0;
  assign rx_valid = rx_idx < rx_len;
  assign rx_data  = rx_src[rx_idx[3:0]];
  assign rx_last  = rx_lf[rx_idx[3:0]];
  always @(posedge clk) if (rx_valid && rx_ready) rx_idx <= rx_idx + 1;

  int irq_n = 0;
  always @(posedge clk) if (irq) irq_n <= irq_n + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cw(input int op, input int key, input int im, input int bm, input int wm);
    cw = 16'((op << 12) | (key << 8) | (im << 4) | (bm << 2) | wm);
  endfunction

  task automatic put_desc(input int base, input logic [15:0] cmd, input logic [15:0] cnt,
                          input logic [31:0] addr, input logic [31:0] dep);
    mem[base/4]     = {cmd, cnt};
    mem[base/4 + 1] = addr;
    mem[base/4 + 2] = dep;
    mem[base/4 + 3] = 32'hDEADBEEF;
  endtask

  task automatic clear_all();
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    irq_n = 0; tx_n = 0; rx_idx = 0; rx_len = 0;
  endtask

  task automatic run_chain(input logic [31:0] start, input string req);
    bit seen = 0, done = 0;
    @(negedge clk); run = 0;
    repeat (2) @(negedge clk);
    cmd_start = start; run = 1;
    for (int i = 0; i < 3000 && !done; i++) begin
      @(negedge clk);
      if (status[10]) seen = 1;
      else if (seen) done = 1;
    end
    chk(done, req, {31'b0, done}, 32'h1);
  endtask

  task automatic t_reset();
    chk(status[10] == 0 && status[8] == 0, "R13", {16'b0, status}, 32'h0);
    chk(!irq && !mem_req && !tx_valid && !rx_ready && !dev_req, "R13",
        {27'b0, irq, mem_req, tx_valid, rx_ready, dev_req}, 32'h0);
  endtask

  task automatic t_send();
    clear_all();
    mem[32'h100/4] = 32'h44332211;
    mem[32'h180/4] = 32'h0000BBAA;
    put_desc(32'h00, cw(0, 1, 0, 0, 0), 16'd3, 32'h101, 0);
    put_desc(32'h10, cw(1, 0, 3, 0, 0), 16'd2, 32'h180, 0);
    put_desc(32'h20, cw(7, 0, 0, 0, 0), 16'd0, 0, 0);
    tx_throttle = 1;
    run_chain(32'h0, "R1");
    tx_throttle = 0;
    chk(tx_n == 5, "R2", tx_n, 5);
    chk({tx_log[0], tx_log[1], tx_log[2], tx_log[3], tx_log[4]} == 40'h223344AABB, "R2",
        {tx_log[0], tx_log[1], tx_log[2], tx_log[3]}, 32'h223344AA);
    chk({tx_lastlog[0], tx_lastlog[1], tx_lastlog[2], tx_lastlog[3], tx_lastlog[4]} == 5'b00001,
        "R2", {27'b0, tx_lastlog[0], tx_lastlog[1], tx_lastlog[2], tx_lastlog[3], tx_lastlog[4]}, 1);
    chk({tx_idlog[0], tx_idlog[2], tx_idlog[4]} == 6'b010100, "R2",
        {26'b0, tx_idlog[0], tx_idlog[2], tx_idlog[4]}, 32'h14);
    chk(mem[32'h1C/4] == 32'h845A0000, "R8", mem[32'h1C/4], 32'h845A0000);
    chk(irq_n == 1, "R9", irq_n, 1);
    chk(mem[32'h2C/4] == 32'hDEADBEEF, "R10", mem[32'h2C/4], 32'hDEADBEEF);
    begin
      bit quiet = 1;
      repeat (20) begin @(negedge clk); if (mem_req || status[10]) quiet = 0; end
      chk(quiet, "R10", {31'b0, quiet}, 1);
    end
  endtask

  task automatic t_recv();
    clear_all();
    rx_src[0] = 8'hA1; rx_lf[0] = 0; rx_src[1] = 8'hA2; rx_lf[1] = 1;
    rx_src[2] = 8'hA3; rx_lf[2] = 0; rx_src[3] = 8'hA4; rx_lf[3] = 0;
    rx_src[4] = 8'hB1; rx_lf[4] = 0; rx_src[5] = 8'hB2; rx_lf[5] = 0;
    rx_src[6] = 8'hB3; rx_lf[6] = 1; rx_src[7] = 8'hCC; rx_lf[7] = 0;
    put_desc(32'h00, cw(2, 0, 0, 0, 0), 16'd4, 32'h202, 0);
    put_desc(32'h10, cw(3, 0, 0, 0, 0), 16'd8, 32'h300, 0);
    put_desc(32'h20, cw(7, 0, 0, 0, 0), 16'd0, 0, 0);
    rx_len = 8;
    run_chain(32'h0, "R3");
    chk(mem[32'h200/4] == 32'hA2A10000, "R3", mem[32'h200/4], 32'hA2A10000);
    chk(mem[32'h204/4] == 32'h0000A4A3, "R3", mem[32'h204/4], 32'h0000A4A3);
    chk(mem[32'h300/4] == 32'h00B3B2B1, "R3", mem[32'h300/4], 32'h00B3B2B1);
    chk(rx_idx == 7, "R3", rx_idx, 7);
    chk(mem[32'h0C/4] == 32'h845A0000, "R8", mem[32'h0C/4], 32'h845A0000);
    chk(mem[32'h1C/4] == 32'h845A0005, "R8", mem[32'h1C/4], 32'h845A0005);
  endtask

  task automatic t_dev();
    clear_all();
    put_desc(32'h00, cw(4, 5, 0, 0, 0), 16'd4, 32'h30, 32'hCAFEF00D);
    put_desc(32'h10, cw(5, 5, 0, 0, 0), 16'd4, 32'h34, 32'h0);
    put_desc(32'h20, cw(7, 0, 0, 0, 0), 16'd0, 0, 0);
    run_chain(32'h0, "R4");
    chk(dv_wdata == 32'hCAFEF00D && dv_waddr == 32'h30, "R4", dv_wdata, 32'hCAFEF00D);
    chk(mem[32'h18/4] == 32'h12340034, "R4", mem[32'h18/4], 32'h12340034);
  endtask

  task automatic t_branch();
    clear_all();
    put_desc(32'h00, cw(6, 0, 0, 3, 0), 0, 0, 32'h4C);
    put_desc(32'h10, cw(7, 0, 0, 0, 0), 0, 0, 0);
    put_desc(32'h40, cw(6, 0, 0, 0, 0), 0, 0, 0);
    put_desc(32'h50, cw(7, 0, 0, 0, 0), 0, 0, 0);
    run_chain(32'h0, "R6");
    chk(mem[32'h0C/4] == 32'h855A0000, "R6", mem[32'h0C/4], 32'h855A0000);
    chk(mem[32'h4C/4] == 32'h845A0000, "R6", mem[32'h4C/4], 32'h845A0000);
    // condition false: mask FF value 00 against status 5A
    clear_all();
    br_sel = 16'hFF00;
    put_desc(32'h00, cw(6, 0, 0, 1, 0), 0, 0, 32'h40);
    put_desc(32'h10, cw(6, 0, 0, 0, 0), 0, 0, 0);
    put_desc(32'h20, cw(7, 0, 0, 0, 0), 0, 0, 0);
    put_desc(32'h40, cw(7, 0, 0, 0, 0), 0, 0, 0);
    run_chain(32'h0, "R5");
    chk(mem[32'h1C/4] == 32'h845A0000 && mem[32'h0C/4] == 32'h845A0000, "R5",
        mem[32'h1C/4], 32'h845A0000);
    br_sel = 0;
  endtask

  task automatic t_irq();
    clear_all();
    int_sel = 16'hFF5A;
    put_desc(32'h00, cw(6, 0, 1, 0, 0), 0, 0, 0);
    put_desc(32'h10, cw(6, 0, 2, 0, 0), 0, 0, 0);
    put_desc(32'h20, cw(6, 0, 0, 0, 0), 0, 0, 0);
    put_desc(32'h30, cw(7, 0, 0, 0, 0), 0, 0, 0);
    run_chain(32'h0, "R9");
    chk(irq_n == 1, "R9", irq_n, 1);
    int_sel = 0;
  endtask

  task automatic t_wait();
    clear_all();
    wait_sel = 16'h0101;
    dev_status = 8'h5B;
    put_desc(32'h00, cw(6, 0, 0, 0, 1), 0, 0, 0);
    put_desc(32'h10, cw(7, 0, 0, 0, 0), 0, 0, 0);
    @(negedge clk); run = 0;
    repeat (2) @(negedge clk);
    cmd_start = 0; run = 1;
    repeat (30) @(negedge clk);
    chk(status[10] && mem[32'h0C/4] == 32'hDEADBEEF, "R7", mem[32'h0C/4], 32'hDEADBEEF);
    dev_status = 8'h5A;
    repeat (30) @(negedge clk);
    chk(!status[10] && mem[32'h0C/4] == 32'h845A0000, "R7", mem[32'h0C/4], 32'h845A0000);
    wait_sel = 0;
  endtask

  task automatic t_abort();
    clear_all();
    mem[32'h100/4] = 32'h04030201;
    put_desc(32'h00, cw(0, 0, 0, 0, 0), 16'd4, 32'h100, 0);
    tx_hold = 1;
    @(negedge clk); run = 0;
    repeat (2) @(negedge clk);
    cmd_start = 0; run = 1;
    repeat (20) @(negedge clk);
    chk(tx_valid, "R11", {31'b0, tx_valid}, 1);
    run = 0;
    @(negedge clk);
    chk(!tx_valid && !status[10] && !mem_req, "R11",
        {29'b0, tx_valid, status[10], mem_req}, 0);
    tx_hold = 0;
  endtask

  task automatic t_pause();
    bit quiet = 1;
    clear_all();
    put_desc(32'h00, cw(6, 0, 0, 0, 0), 0, 0, 0);
    put_desc(32'h10, cw(7, 0, 0, 0, 0), 0, 0, 0);
    pause = 1;
    @(negedge clk); run = 0;
    repeat (2) @(negedge clk);
    cmd_start = 0; run = 1;
    repeat (10) begin @(negedge clk); if (mem_req) quiet = 0; end
    chk(quiet && status[14], "R12", {31'b0, quiet}, 1);
    pause = 0;
    repeat (40) @(negedge clk);
    chk(mem[32'h0C/4] == 32'h845A0000, "R12", mem[32'h0C/4], 32'h845A0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_send();
    t_recv();
    t_dev();
    t_branch();
    t_irq();
    t_wait();
    t_abort();
    t_pause();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule